// File: doc/BRIEF.md
# UART Interrupt Status Logic

This block forms the raw and masked interrupt status for the transmit, receive and clear-to-send events of a UART. It watches the fill counts of the transmit and receive FIFOs. With FIFOs enabled, it compares each count against a programmable trigger level. With FIFOs disabled, each direction is treated as a single holding location, and the block watches whether that location is occupied. The clear-to-send pin goes through a two-stage synchronizer, and any change of its level raises a modem event.

Each interrupt bit is set only in the cycle in which its condition turns true. The bit stays set until the condition goes false or software writes a one to the matching bit of the clear register. Because of this, a bit that software has cleared stays low until the condition has been left and entered again. A mask selects which raw bits reach the masked word, and the OR of the masked word drives a single interrupt line.

The block has no streaming interface. Every input and output is a plain level or a strobe that is sampled on the rising clock edge, so no back-pressure applies.

Top module: `uart_irq_status`

## Requirements
- R1: While `rst_n` is low, `raw_status`, `masked_status` and `irq` are all zero.
- R2: In `raw_status`, bit 5 is the transmit interrupt, bit 4 is the receive interrupt and bit 1 is the CTS interrupt. Bits 3, 2 and 0 always read 0.
- R3: When `fifo_en`=1, bit 5 sets at the clock edge where `tx_count` <= the transmit trigger level first becomes true. It clears at any edge where `tx_count` is above that level.
- R4: When `fifo_en`=1, bit 4 sets at the clock edge where `rx_count` >= the receive trigger level first becomes true. It clears at any edge where `rx_count` is below that level.
- R5: A trigger select (`tx_trig_sel`, `rx_trig_sel`) maps as follows for a 32-entry FIFO: 0 to 4, 1 to 8, 2 to 16, 3 to 24, 4 to 28. The encodings 5, 6 and 7 map to 16.
- R6: When `fifo_en`=0, bit 5 sets at the edge where `tx_count`==0 first becomes true and clears at any edge where `tx_count`!=0.
- R7: When `fifo_en`=0, bit 4 sets at the edge where `rx_count`!=0 first becomes true and clears at any edge where `rx_count`==0.
- R8: A condition that stays true does not set its bit again. After a clear, the bit stays 0 until the condition has gone false and then become true again.
- R9: An edge with `clr_wr`=1 clears each of raw bits 5, 4 and 1 whose matching bit in `clr_data` is 1. Bits written as 0 are unaffected. A set event in the same cycle wins over the clear.
- R10: A change of `cts_in` sets bit 1 at the third rising edge after the change. This delay comes from two synchronizer stages and one compare stage. The synchronizer resets to 0.
- R11: `masked_status` equals `raw_status` AND `irq_mask`, and `irq` is 1 exactly when `masked_status` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects single-location mode |
| tx_count | input | 6 | Transmit FIFO fill count (0 to 32) |
| rx_count | input | 6 | Receive FIFO fill count (0 to 32) |
| tx_trig_sel | input | 3 | Transmit trigger level select |
| rx_trig_sel | input | 3 | Receive trigger level select |
| cts_in | input | 1 | Asynchronous clear-to-send pin |
| irq_mask | input | 6 | Interrupt mask, one bit per status bit |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_data | input | 6 | Write-one-to-clear data |
| raw_status | output | 6 | Raw interrupt status |
| masked_status | output | 6 | Raw status AND mask |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a clear written while the condition still holds. The bit must then stay low until the condition is left and entered again, and this path is exercised only when the count is held steady across the clear and the following cycles. The bench sets this up directly in both directions. It then runs a long phase in which the counts, the mode, the trigger selects, the CTS pin, the mask and the clear writes change at random. A behavioural model follows every cycle of that phase, so set and clear events that fall on the same edge, and switches of mode while a bit is set, are covered.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STAT_W  = 6;
  localparam int BIT_TX  = 5;
  localparam int BIT_RX  = 4;
  localparam int BIT_CTS = 1;
  localparam int SEL_W   = 3;
endpackage

// File: rtl/irq_trig_decode.sv
// Maps a 3-bit trigger select to a FIFO fill level (R5).
module irq_trig_decode #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [uart_irq_pkg::SEL_W-1:0] sel,
  output logic [CNT_W-1:0]               level
);
  localparam int L_EIGHTH  = DEPTH / 8;
  localparam int L_QUARTER = DEPTH / 4;
  localparam int L_HALF    = DEPTH / 2;
  localparam int L_3Q      = (3 * DEPTH) / 4;
  localparam int L_7E      = (7 * DEPTH) / 8;

  always_comb begin
    case (sel)
      3'd0:    level = CNT_W'(L_EIGHTH);
      3'd1:    level = CNT_W'(L_QUARTER);
      3'd3:    level = CNT_W'(L_3Q);
      3'd4:    level = CNT_W'(L_7E);
      default: level = CNT_W'(L_HALF);
    endcase
  end
endmodule

// File: rtl/irq_level_src.sv
// One FIFO-driven interrupt source; IS_RX picks the receive rule set.
module irq_level_src #(
  parameter int CNT_W = 6,
  parameter bit IS_RX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] level,
  input  logic             clr,
  output logic             flag
);
  logic cond, cond_q, rise;

  generate
    if (IS_RX) begin : g_rx
      // R4 / R7
      assign cond = fifo_en ? (count >= level) : (count != '0);
    end else begin : g_tx
      // R3 / R6
      assign cond = fifo_en ? (count <= level) : (count == '0);
    end
  endgenerate

  assign rise = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      cond_q <= cond;
      if (rise)             flag <= 1'b1;  // R8 edge-set, R9 set wins
      else if (!cond || clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cts_detect.sv
// Synchronizes the CTS pin and flags every level change (R10).
module irq_cts_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic clr,
  output logic flag
);
  logic sync1, sync2, last;
  logic change;

  assign change = sync2 ^ last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      last  <= 1'b0;
      flag  <= 1'b0;
    end else begin
      sync1 <= cts_in;
      sync2 <= sync1;
      last  <= sync2;
      if (change)   flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  fifo_en,
  input  logic [CNT_W-1:0]                      tx_count,
  input  logic [CNT_W-1:0]                      rx_count,
  input  logic [uart_irq_pkg::SEL_W-1:0]        tx_trig_sel,
  input  logic [uart_irq_pkg::SEL_W-1:0]        rx_trig_sel,
  input  logic                                  cts_in,
  input  logic [uart_irq_pkg::STAT_W-1:0]       irq_mask,
  input  logic                                  clr_wr,
  input  logic [uart_irq_pkg::STAT_W-1:0]       clr_data,
  output logic [uart_irq_pkg::STAT_W-1:0]       raw_status,
  output logic [uart_irq_pkg::STAT_W-1:0]       masked_status,
  output logic                                  irq
);
  import uart_irq_pkg::*;

  logic [CNT_W-1:0] tx_level, rx_level;
  logic tx_flag, rx_flag, cts_flag;

  irq_trig_decode #(.DEPTH(DEPTH)) u_tx_dec (.sel(tx_trig_sel), .level(tx_level));
  irq_trig_decode #(.DEPTH(DEPTH)) u_rx_dec (.sel(rx_trig_sel), .level(rx_level));

  irq_level_src #(.CNT_W(CNT_W), .IS_RX(1'b0)) u_tx_src (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .count(tx_count),
    .level(tx_level), .clr(clr_wr & clr_data[BIT_TX]), .flag(tx_flag));

  irq_level_src #(.CNT_W(CNT_W), .IS_RX(1'b1)) u_rx_src (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .count(rx_count),
    .level(rx_level), .clr(clr_wr & clr_data[BIT_RX]), .flag(rx_flag));

  irq_cts_detect u_cts (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in),
    .clr(clr_wr & clr_data[BIT_CTS]), .flag(cts_flag));

  // R2: fixed layout, reserved bits tied low
  always_comb begin
    raw_status          = '0;
    raw_status[BIT_TX]  = tx_flag;
    raw_status[BIT_RX]  = rx_flag;
    raw_status[BIT_CTS] = cts_flag;
  end

  // R11
  assign masked_status = raw_status & irq_mask;
  assign irq           = |masked_status;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic [2:0]       tx_trig_sel,
  input logic [5:0]       irq_mask,
  input logic             clr_wr,
  input logic [5:0]       clr_data,
  input logic [5:0]       raw_status,
  input logic             irq
);
  logic settled;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settled <= 1'b0;
    else        settled <= 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[3:2] == 2'b00) && (raw_status[0] == 1'b0));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_status & irq_mask) != 6'd0));

  // R4
  rx_below_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count < CNT_W'(DEPTH / 8)) |=> !raw_status[4]);

  // R6
  tx_single_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && tx_count != '0) |=> !raw_status[5]);

  // R7
  rx_single_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_count == '0) |=> !raw_status[4]);

  // R9
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && clr_wr && clr_data[5] && $stable(tx_count) && $stable(fifo_en)
     && $stable(tx_trig_sel)) |=> !raw_status[5]);
endmodule

bind uart_irq_status uart_irq_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_count(tx_count),
  .rx_count(rx_count), .tx_trig_sel(tx_trig_sel), .irq_mask(irq_mask),
  .clr_wr(clr_wr), .clr_data(clr_data), .raw_status(raw_status), .irq(irq));

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1;
  logic [5:0] tx_count = 6'd0, rx_count = 6'd0;
  logic [2:0] tx_trig_sel = 3'd0, rx_trig_sel = 3'd0;
  logic cts_in = 1'b0;
  logic [5:0] irq_mask = 6'd0;
  logic clr_wr = 1'b0;
  logic [5:0] clr_data = 6'd0;
  logic [5:0] raw_status, masked_status;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_status u_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_count(tx_count),
    .rx_count(rx_count), .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
    .cts_in(cts_in), .irq_mask(irq_mask), .clr_wr(clr_wr), .clr_data(clr_data),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq));

  // behavioural reference model
  bit m_tx, m_rx, m_cts, m_tq, m_rq;
  int m_s1, m_s2, m_s3;

  function automatic int trig_of(int s);
    if (s == 0) return 4;
    if (s == 1) return 8;
    if (s == 3) return 24;
    if (s == 4) return 28;
    return 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_cts = 0; m_tq = 0; m_rq = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit tc, rc;
      tc = fifo_en ? (int'(tx_count) <= trig_of(tx_trig_sel)) : (tx_count == 0);
      rc = fifo_en ? (int'(rx_count) >= trig_of(rx_trig_sel)) : (rx_count != 0);
      if (tc && !m_tq) m_tx = 1;
      else if (!tc || (clr_wr && clr_data[5])) m_tx = 0;
      if (rc && !m_rq) m_rx = 1;
      else if (!rc || (clr_wr && clr_data[4])) m_rx = 0;
      if (m_s2 != m_s3) m_cts = 1;
      else if (clr_wr && clr_data[1]) m_cts = 0;
      m_tq = tc; m_rq = rc;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_in;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the model, away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [5:0] exp_raw;
    exp_raw = {m_tx, m_rx, 2'b00, m_cts, 1'b0};
    check("R3 R6 tx bit", raw_status[5], exp_raw[5]);
    check("R4 R7 rx bit", raw_status[4], exp_raw[4]);
    check("R10 cts bit", raw_status[1], exp_raw[1]);
    check("R2 reserved", {raw_status[3:2], raw_status[0]}, 0);
    check("R11 masked", masked_status, exp_raw & irq_mask);
    check("R11 irq", irq, (exp_raw & irq_mask) != 0);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    // R1
    step(3);
    check("R1 raw in reset", raw_status, 0);
    check("R1 irq in reset", irq, 0);
    irq_mask = 6'h3f;
    rst_n = 1'b1;
    step(1);
    // tx FIFO empty at or below level 4: set right after reset (R3)
    check("R3 tx set after reset", raw_status[5], 1);
    tx_count = 6'd5; step(1);
    check("R3 tx cleared above level", raw_status[5], 0);
    // R5: select 7 acts as half (16)
    tx_trig_sel = 3'd7; tx_count = 6'd17; step(1);
    tx_count = 6'd16; step(1);
    check("R5 sel7 level16 tx set", raw_status[5], 1);
    rx_trig_sel = 3'd4; rx_count = 6'd27; step(1);
    check("R5 sel4 level28 rx not yet", raw_status[4], 0);
    rx_count = 6'd28; step(1);
    check("R4 rx set at level", raw_status[4], 1);
    // R8 + R9: clear while condition holds, stays clear
    clr_wr = 1; clr_data = 6'h10; step(1);
    clr_wr = 0; clr_data = 0;
    check("R9 rx cleared by write", raw_status[4], 0);
    check("R9 tx untouched by zero bit", raw_status[5], 1);
    step(3);
    check("R8 rx stays clear", raw_status[4], 0);
    rx_count = 6'd20; step(1);
    rx_count = 6'd30; step(1);
    check("R8 rx re-armed", raw_status[4], 1);
    // R6/R7 single-location mode
    fifo_en = 0; tx_count = 6'd1; rx_count = 6'd0; step(1);
    check("R6 tx clear when occupied", raw_status[5], 0);
    check("R7 rx clear when empty", raw_status[4], 0);
    tx_count = 0; rx_count = 1; step(1);
    check("R6 tx set when empty", raw_status[5], 1);
    check("R7 rx set when filled", raw_status[4], 1);
    // R10 CTS delay
    clr_wr = 1; clr_data = 6'h02; step(1); clr_wr = 0; clr_data = 0;
    cts_in = 1; step(2);
    check("R10 cts not yet", raw_status[1], 0);
    step(1);
    check("R10 cts set", raw_status[1], 1);
    // R11 masking
    irq_mask = 6'h02; step(1);
    check("R11 masked only cts", masked_status, 6'h02);
    irq_mask = 6'h00; step(1);
    check("R11 irq off when masked", irq, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) fifo_en = ~fifo_en;
      if (r < 40) tx_count = ($urandom_range(0, 1) != 0) ? 6'($urandom_range(0, 32))
                              : ((tx_count < 32) ? tx_count + 1 : 6'd0);
      if (r > 55) rx_count = ($urandom_range(0, 1) != 0) ? 6'($urandom_range(0, 32))
                              : ((rx_count > 0) ? rx_count - 1 : 6'd32);
      if (r == 50) tx_trig_sel = 3'($urandom_range(0, 7));
      if (r == 51) rx_trig_sel = 3'($urandom_range(0, 7));
      if (r % 17 == 0) cts_in = ~cts_in;
      if (r % 11 == 0) irq_mask = 6'($urandom_range(0, 63));
      clr_wr = ($urandom_range(0, 7) == 0);
      clr_data = 6'($urandom_range(0, 63));
      step(1);
    end
    clr_wr = 0;
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule